// File: doc/BRIEF.md
# Packed Double-to-Int32 Converter

This block converts two IEEE-754 double-precision values packed into a 128-bit word into two signed 32-bit integers packed into a 64-bit word. The two lanes are converted independently and in parallel. A 2-bit rounding-mode input chooses how results that are not whole numbers are rounded. Any lane that holds a NaN or an infinity, or whose rounded value falls outside the signed 32-bit range, is flagged as invalid. When the invalid exception is masked, such a lane returns the indefinite integer 0x80000000.

Each lane passes through three stages: a classifier that unpacks the fields, an aligner that shifts the significand into a fixed-point integer with guard and sticky bits, and a rounder that applies the rounding mode and checks the range. The packed result and the status bits are captured in registers on the clock edge that follows the inputs. The surrounding pipeline uses the invalid flag to decide whether a trap is needed.

Top module: `pkd_f64_to_i32`

## Requirements
- R1: Source bits 63:0 convert into result bits 31:0, and source bits 127:64 convert into result bits 63:32. Each lane's outcome depends only on its own source lane. Per-lane flag bit 0 belongs to the low lane and bit 1 to the high lane.
- R2: All outputs are registered and show the conversion of the inputs present at the previous rising clock edge. While the synchronous active-high reset is asserted, every output is zero.
- R3: Source values that are already whole numbers inside the 32-bit signed range, including -2^31, 2^31-1 and zeros of either sign, convert exactly and raise no flag.
- R4: The rounding mode is encoded as 00 = nearest with ties to even, 01 = toward minus infinity, 10 = toward plus infinity, 11 = toward zero.
- R5: A quiet or signalling NaN lane raises that lane's invalid bit. With the mask input at 1, its result is 0x80000000.
- R6: A lane holding plus or minus infinity raises its invalid bit. With the mask input at 1, its result is 0x80000000.
- R7: The range check is applied after rounding. A rounded value below -2^31 or above 2^31-1 raises the invalid bit and returns 0x80000000 when masked. A value that rounds to exactly -2^31 is valid.
- R8: Subnormals and values of magnitude below one convert to 0, or to +1 or -1 when the rounding direction demands it, and they set inexact.
- R9: A lane's inexact bit is set only when the lane is valid and its source had a nonzero fractional part. An invalid lane never reports inexact.
- R10: With the mask input at 0, an invalid lane still raises its invalid bit, and its result field is 0x00000000.
- R11: The summary outputs invalid_o and inexact_o are the OR of the corresponding per-lane bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 128 | Two packed double-precision operands |
| rmode_i | input | 2 | Rounding mode (see R4) |
| inv_mask_i | input | 1 | 1 = invalid exception masked |
| res_o | output | 64 | Two packed signed 32-bit results |
| lane_inv_o | output | 2 | Per-lane invalid bits |
| lane_inx_o | output | 2 | Per-lane inexact bits |
| invalid_o | output | 1 | OR of the per-lane invalid bits |
| inexact_o | output | 1 | OR of the per-lane inexact bits |

## Verification
The bench drives the following patterns, and each one separates a different kind of fault:
- Exact whole numbers at both ends of the range, and signed zeros, catch alignment and negation faults.
- Halfway values such as ±2.5 and ±3.5 under all four rounding modes catch a mode decoder that mixes up the directions or drops the ties-to-even rule.
- Values just outside the range, such as 2147483647.5 and -2147483648.5, together with their in-range counterparts like -2147483648.4, show whether the range check runs before or after rounding.
- NaN, infinity and subnormal inputs, placed in one lane while the other lane holds an ordinary value, expose lane swaps, flag leakage between lanes and a wrong mask behaviour.

// File: rtl/pd2i_pkg.sv
package pd2i_pkg;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_DOWN      = 2'b01,
    RM_UP        = 2'b10,
    RM_ZERO      = 2'b11
  } rmode_e;

endpackage

// File: rtl/f64_classify.sv
module f64_classify #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  localparam int FP_W = 1 + EXP_W + MAN_W
) (
  input  logic [FP_W-1:0]  word_i,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [MAN_W:0]   sig_o,
  output logic             nan_o,
  output logic             inf_o,
  output logic             zero_o,
  output logic             sub_o
);
  logic [EXP_W-1:0] e;
  logic [MAN_W-1:0] f;
  logic             e_max, e_min, f_nz;

  always_comb begin
    e      = word_i[FP_W-2 -: EXP_W];
    f      = word_i[MAN_W-1:0];
    e_max  = &e;
    e_min  = ~|e;
    f_nz   = |f;
    sign_o = word_i[FP_W-1];
    exp_o  = e;
    sig_o  = {~e_min, f};
    nan_o  = e_max & f_nz;
    inf_o  = e_max & ~f_nz;
    zero_o = e_min & ~f_nz;
    sub_o  = e_min & f_nz;
  end
endmodule

// File: rtl/f64_align.sv
module f64_align #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32,
  localparam int BIAS = (1 << (EXP_W - 1)) - 1,
  localparam int VW   = INT_W + MAN_W + 1,
  localparam int SH_W = $clog2(INT_W + 1)
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W:0]   sig_i,
  input  logic             zero_i,
  input  logic             sub_i,
  output logic [INT_W-1:0] mag_o,
  output logic             guard_o,
  output logic             sticky_o,
  output logic             big_o
);
  // Shift amount s = unbiased exponent + 1, valid for 0..INT_W
  localparam logic [EXP_W-1:0] LO_EXP = EXP_W'(BIAS - 1);
  localparam logic [EXP_W-1:0] HI_EXP = EXP_W'(BIAS + INT_W - 1);

  logic [SH_W-1:0] sh;
  logic [VW-1:0]   fx;

  always_comb begin
    sh       = SH_W'(exp_i - LO_EXP);
    fx       = {{INT_W{1'b0}}, sig_i} << sh;
    mag_o    = '0;
    guard_o  = 1'b0;
    sticky_o = 1'b0;
    big_o    = 1'b0;
    if (zero_i) begin
      // all zero
    end else if (sub_i) begin
      sticky_o = 1'b1;
    end else if (exp_i > HI_EXP) begin
      big_o = 1'b1;
    end else if (exp_i < LO_EXP) begin
      sticky_o = 1'b1;
    end else begin
      mag_o    = fx[VW-1 -: INT_W];
      guard_o  = fx[MAN_W];
      sticky_o = |fx[MAN_W-1:0];
    end
  end
endmodule

// File: rtl/i32_round.sv
module i32_round
  import pd2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic             sign_i,
  input  logic [INT_W-1:0] mag_i,
  input  logic             guard_i,
  input  logic             sticky_i,
  input  logic             big_i,
  input  logic             special_i,
  input  logic [1:0]       rmode_i,
  output logic [INT_W-1:0] val_o,
  output logic             inv_o,
  output logic             inx_o
);
  logic           inc, frac_nz, fits;
  logic [INT_W:0] mr;
  rmode_e         md;

  always_comb begin
    md      = rmode_e'(rmode_i);
    frac_nz = guard_i | sticky_i;
    case (md)
      RM_NEAR_EVEN: inc = guard_i & (sticky_i | mag_i[0]);
      RM_DOWN:      inc = frac_nz & sign_i;
      RM_UP:        inc = frac_nz & ~sign_i;
      default:      inc = 1'b0;
    endcase
    mr = {1'b0, mag_i} + {{INT_W{1'b0}}, inc};
    if (sign_i)
      fits = ~mr[INT_W] & (~mr[INT_W-1] | ~|mr[INT_W-2:0]);
    else
      fits = ~mr[INT_W] & ~mr[INT_W-1];
    val_o = sign_i ? (~mr[INT_W-1:0] + 1'b1) : mr[INT_W-1:0];
    inv_o = special_i | big_i | ~fits;
    inx_o = ~inv_o & frac_nz;
  end

  // R4: an increment is only possible when something was discarded
  always_comb begin
    a_r4_inc_needs_frac: assert (!inc || guard_i || sticky_i)
      else $error("rounding increment without discarded bits");
  end
endmodule

// File: rtl/pkd_f64_to_i32.sv
module pkd_f64_to_i32 #(
  parameter int LANES = 2,
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32,
  localparam int FP_W  = 1 + EXP_W + MAN_W,
  localparam int SRC_W = LANES * FP_W,
  localparam int DST_W = LANES * INT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] src_i,
  input  logic [1:0]       rmode_i,
  input  logic             inv_mask_i,
  output logic [DST_W-1:0] res_o,
  output logic [LANES-1:0] lane_inv_o,
  output logic [LANES-1:0] lane_inx_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

  logic [DST_W-1:0] res_d;
  logic [LANES-1:0] inv_d, inx_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic             sgn, nan, inf, zro, sub, grd, stk, big, l_inv, l_inx;
    logic [EXP_W-1:0] ex;
    logic [MAN_W:0]   sig;
    logic [INT_W-1:0] mag, val;

    f64_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .word_i (src_i[g*FP_W +: FP_W]),
      .sign_o (sgn), .exp_o (ex), .sig_o (sig),
      .nan_o  (nan), .inf_o (inf), .zero_o (zro), .sub_o (sub)
    );

    f64_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_aln (
      .exp_i (ex), .sig_i (sig), .zero_i (zro), .sub_i (sub),
      .mag_o (mag), .guard_o (grd), .sticky_o (stk), .big_o (big)
    );

    i32_round #(.INT_W(INT_W)) u_rnd (
      .sign_i (sgn), .mag_i (mag), .guard_i (grd), .sticky_i (stk),
      .big_i (big), .special_i (nan | inf), .rmode_i (rmode_i),
      .val_o (val), .inv_o (l_inv), .inx_o (l_inx)
    );

    always_comb begin
      inv_d[g] = l_inv;
      inx_d[g] = l_inx;
      if (!l_inv)
        res_d[g*INT_W +: INT_W] = val;
      else if (inv_mask_i)
        res_d[g*INT_W +: INT_W] = INDEF;
      else
        res_d[g*INT_W +: INT_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o      <= '0;
      lane_inv_o <= '0;
      lane_inx_o <= '0;
      invalid_o  <= 1'b0;
      inexact_o  <= 1'b0;
    end else begin
      res_o      <= res_d;
      lane_inv_o <= inv_d;
      lane_inx_o <= inx_d;
      invalid_o  <= |inv_d;
      inexact_o  <= |inx_d;
    end
  end

  for (genvar a = 0; a < LANES; a++) begin : g_chk
    // R5/R6/R7: masked invalid lane carries the indefinite integer
    a_r5_masked_indef: assert property (@(posedge clk) disable iff (rst)
      (lane_inv_o[a] && $past(inv_mask_i)) |-> res_o[a*INT_W +: INT_W] == INDEF)
      else $error("masked invalid lane not indefinite");
    // R9: a lane is never both invalid and inexact
    a_r9_inx_excl: assert property (@(posedge clk) disable iff (rst)
      !(lane_inv_o[a] && lane_inx_o[a]))
      else $error("lane both invalid and inexact");
    // R1: a valid lane keeps the sign of its own source lane
    a_r1_pos_sign: assert property (@(posedge clk) disable iff (rst)
      (!lane_inv_o[a] && !$past(src_i[a*FP_W + FP_W - 1]))
        |-> !res_o[a*INT_W + INT_W - 1])
      else $error("positive source gave negative result");
  end
endmodule

// File: tb/pkd_f64_to_i32_test.sv
module pkd_f64_to_i32_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] src = '0;
  logic [1:0]   rm = 2'b00;
  logic         msk = 1'b1;
  logic [63:0]  res;
  logic [1:0]   linv, linx;
  logic         inv, inx;
  int n_chk = 0;
  int n_bad = 0;

  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [31:0] IND  = 32'h8000_0000;

  always #2 clk = ~clk;

  pkd_f64_to_i32 uut (
    .clk(clk), .rst(rst), .src_i(src), .rmode_i(rm), .inv_mask_i(msk),
    .res_o(res), .lane_inv_o(linv), .lane_inx_o(linx),
    .invalid_o(inv), .inexact_o(inx)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(input logic [63:0] hi, input logic [63:0] lo,
                     input logic [1:0] m, input logic k);
    @(negedge clk);
    src = {hi, lo}; rm = m; msk = k;
    @(negedge clk);
  endtask

  task automatic expect_all(input string req, input logic [63:0] r,
                            input logic [1:0] vi, input logic [1:0] vx);
    chk(req, res, r);
    chk({req, " lane_inv"}, {62'd0, linv}, {62'd0, vi});
    chk({req, " lane_inx"}, {62'd0, linx}, {62'd0, vx});
    chk("R11 invalid_o", {63'd0, inv}, {63'd0, |vi});
    chk("R11 inexact_o", {63'd0, inx}, {63'd0, |vx});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R2 reset res", res, 64'd0);
    chk("R2 reset flags", {60'd0, linv, linx}, 64'd0);
    chk("R2 reset summary", {62'd0, inv, inx}, 64'd0);
  endtask

  task automatic t_exact;
    run($realtobits(-7.0), $realtobits(5.0), 2'b00, 1'b1);
    expect_all("R1 R3 lanes", {32'hFFFF_FFF9, 32'h0000_0005}, 2'b00, 2'b00);
    run(64'h8000_0000_0000_0000, 64'd0, 2'b01, 1'b1);
    expect_all("R3 signed zeros", 64'd0, 2'b00, 2'b00);
    run($realtobits(2147483647.0), $realtobits(-2147483648.0), 2'b00, 1'b1);
    expect_all("R3 range ends", {32'h7FFF_FFFF, IND}, 2'b00, 2'b00);
  endtask

  task automatic t_round;
    run($realtobits(2.5), $realtobits(-2.5), 2'b00, 1'b1);
    expect_all("R4 nearest-even", {32'd2, 32'hFFFF_FFFE}, 2'b00, 2'b11);
    run($realtobits(2.5), $realtobits(-2.5), 2'b01, 1'b1);
    expect_all("R4 down", {32'd2, 32'hFFFF_FFFD}, 2'b00, 2'b11);
    run($realtobits(2.5), $realtobits(-2.5), 2'b10, 1'b1);
    expect_all("R4 up", {32'd3, 32'hFFFF_FFFE}, 2'b00, 2'b11);
    run($realtobits(2.5), $realtobits(-2.5), 2'b11, 1'b1);
    expect_all("R4 zero", {32'd2, 32'hFFFF_FFFE}, 2'b00, 2'b11);
    run($realtobits(3.5), $realtobits(-3.5), 2'b00, 1'b1);
    expect_all("R4 tie odd", {32'd4, 32'hFFFF_FFFC}, 2'b00, 2'b11);
  endtask

  task automatic t_special;
    run($realtobits(1.0), QNAN, 2'b00, 1'b1);
    expect_all("R5 quiet nan", {32'd1, IND}, 2'b01, 2'b00);
    run(SNAN, $realtobits(-4.0), 2'b00, 1'b1);
    expect_all("R5 signalling nan", {IND, 32'hFFFF_FFFC}, 2'b10, 2'b00);
    run(PINF, NINF, 2'b11, 1'b1);
    expect_all("R6 infinities", {IND, IND}, 2'b11, 2'b00);
  endtask

  task automatic t_range;
    run($realtobits(2147483647.5), $realtobits(-2147483648.4), 2'b00, 1'b1);
    expect_all("R7 R9 after rounding", {IND, IND}, 2'b10, 2'b01);
    run($realtobits(2147483647.5), $realtobits(-2147483648.4), 2'b11, 1'b1);
    expect_all("R7 toward zero fits", {32'h7FFF_FFFF, IND}, 2'b00, 2'b11);
    run($realtobits(-2147483649.0), $realtobits(4294967296.0), 2'b00, 1'b1);
    expect_all("R7 beyond range", {IND, IND}, 2'b11, 2'b00);
    run($realtobits(1.0e300), $realtobits(-2147483648.5), 2'b00, 1'b1);
    expect_all("R7 neg tie even", {IND, IND}, 2'b10, 2'b01);
    run($realtobits(1.0e300), $realtobits(-2147483648.5), 2'b01, 1'b1);
    expect_all("R7 neg tie down", {IND, IND}, 2'b11, 2'b00);
  endtask

  task automatic t_tiny;
    run(64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 2'b10, 1'b1);
    expect_all("R8 denormal up", {32'd0, 32'd1}, 2'b00, 2'b11);
    run(64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 2'b01, 1'b1);
    expect_all("R8 denormal down", {32'hFFFF_FFFF, 32'd0}, 2'b00, 2'b11);
    run(64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 2'b00, 1'b1);
    expect_all("R8 denormal nearest", 64'd0, 2'b00, 2'b11);
    run($realtobits(0.3), $realtobits(-0.7), 2'b00, 1'b1);
    expect_all("R8 below one", {32'd0, 32'hFFFF_FFFF}, 2'b00, 2'b11);
  endtask

  task automatic t_unmasked;
    run(QNAN, $realtobits(3.0), 2'b00, 1'b0);
    expect_all("R10 unmasked nan", {32'd0, 32'd3}, 2'b10, 2'b00);
    run($realtobits(2.25), PINF, 2'b00, 1'b0);
    expect_all("R10 unmasked inf", {32'd2, 32'd0}, 2'b01, 2'b10);
  endtask

  task automatic t_latency;
    @(negedge clk);
    src = {$realtobits(9.0), $realtobits(8.0)}; rm = 2'b00; msk = 1'b1;
    @(posedge clk);
    #1;
    chk("R2 one-cycle latency", res, {32'd9, 32'd8});
    src = {$realtobits(6.0), $realtobits(7.0)};
    #1;
    chk("R2 registered hold", res, {32'd9, 32'd8});
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_exact();
        t_round();
        t_special();
        t_range();
        t_tiny();
        t_unmasked();
        t_latency();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule